// File: doc/BRIEF.md
# Capture Input Deglitch Filter

This block cleans one asynchronous capture input before the capture logic sees it. The raw pin first passes through a two-stage synchronizer. The synchronized level is then sampled at one of three rates: every timer clock, every second dead-time enable pulse, or every fourth dead-time enable pulse. A new level is accepted only after it has been seen in a run of consecutive equal samples of the configured length.

A single 4-bit filter code selects both the sample rate and the run length. The run lengths do not rise steadily from one code to the next. Codes outside the filtering set bypass the filter, and the synchronized level then goes straight to the output register. When the output level moves, the block raises a one-cycle rising-edge or falling-edge pulse, which the capture logic can consume directly.

The block has no streaming data path. Every pin is a plain level or strobe, so it has no valid/ready handshake and no back-pressure. Changing the code is a reconfiguration: it restarts the rate divider and the run count.

Top module: `capin_deglitch`

## Requirements
- R1: After reset, and in the first cycle after reset is released, `flt_level`, `rise_pulse` and `fall_pulse` are all 0, whatever the level on `raw_in`.
- R2: Codes 0 and 7 through 15 bypass the filter. `flt_level` then takes a step on `raw_in` three clock edges after `raw_in` changes: two synchronizer stages plus the output register.
- R3: Code 1 needs 2 consecutive equal samples, code 2 needs 4 and code 3 needs 8, with one sample taken on every clock. `flt_level` follows a steady step on `raw_in` after the run length plus 2 clock edges.
- R4: Code 4 needs 6 samples and code 5 needs 8 samples, with one sample taken on every 2nd `dts_tick` pulse. Code 6 needs 6 samples, with one sample taken on every 4th `dts_tick` pulse.
- R5: A sample that differs from the previous sample restarts the run at 1. At clock rate, a new level held for one sample fewer than the run length never reaches `flt_level`. The same level held for exactly the run length does reach `flt_level`.
- R6: Samples equal to the current `flt_level` never change the output. A one-cycle glitch on `raw_in` produces no edge pulse under any filtering code.
- R7: A change of `flt_code` clears both the tick divider and the run count on the next clock edge. After that edge, the Nth `dts_tick` is the first one to produce a sample, where N is 2 or 4.
- R8: `rise_pulse` (or `fall_pulse`) is high for exactly the one cycle in which `flt_level` has just gone from 0 to 1 (or from 1 to 0). The two pulses are never high together.
- R9: The run count never exceeds the configured run length while the code is unchanged and filtering is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dts_tick | input | 1 | One-cycle dead-time sample enable pulse |
| raw_in | input | 1 | Unsynchronized capture input |
| flt_code | input | 4 | Filter code (rate and run length) |
| flt_level | output | 1 | Filtered input level |
| rise_pulse | output | 1 | One-cycle pulse on a 0-to-1 change of `flt_level` |
| fall_pulse | output | 1 | One-cycle pulse on a 1-to-0 change of `flt_level` |

## Verification
The assertions assume that `flt_code` and `dts_tick` are synchronous to `clk`. They also assume that `dts_tick` is a strobe, with no meaning beyond the cycle in which it is high. The bench meets both assumptions. It changes the code and the input only just after a rising edge, and it drives `dts_tick` from a periodic pattern whose phase it counts from the edge that applies each new code. That counted phase lets the bench compute the exact acceptance cycle for the divided-rate codes, with ticks every cycle and every third cycle.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

  localparam int CODE_W  = 4;
  localparam int MAX_RUN = 8;
  localparam int RUN_W   = $clog2(MAX_RUN + 1);

  typedef enum logic [1:0] {
    RATE_CLK  = 2'd0,
    RATE_DIV2 = 2'd1,
    RATE_DIV4 = 2'd2
  } rate_e;

  typedef struct packed {
    logic             bypass;
    rate_e            rate;
    logic [RUN_W-1:0] run_len;
  } flt_cfg_t;

  // Map a filter code to its sample rate and run length
  function automatic flt_cfg_t decode_code(input logic [CODE_W-1:0] c);
    flt_cfg_t r;
    r.bypass  = 1'b0;
    r.rate    = RATE_CLK;
    r.run_len = RUN_W'(1);
    case (c)
      CODE_W'(1): r.run_len = RUN_W'(2);
      CODE_W'(2): r.run_len = RUN_W'(4);
      CODE_W'(3): r.run_len = RUN_W'(8);
      CODE_W'(4): begin r.rate = RATE_DIV2; r.run_len = RUN_W'(6); end
      CODE_W'(5): begin r.rate = RATE_DIV2; r.run_len = RUN_W'(8); end
      CODE_W'(6): begin r.rate = RATE_DIV4; r.run_len = RUN_W'(6); end
      default:    r.bypass = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dgf_sync.sv
module dgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[i] <= 1'b0;
        else        ff_q[i] <= (i == 0) ? d : ff_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/dgf_rate_gen.sv
module dgf_rate_gen
  import dgf_pkg::*;
#(
  parameter int DIV_MAX = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  tick,
  input  rate_e rate,
  output logic  smp_en
);
  localparam int DIV_W = $clog2(DIV_MAX);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_top;

  always_comb begin
    case (rate)
      RATE_DIV4: div_top = DIV_W'(3);
      RATE_DIV2: div_top = DIV_W'(1);
      default:   div_top = '0;
    endcase
  end

  // Free-running count of tick pulses, restarted on reconfiguration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (clr)  div_q <= '0;
    else if (tick) div_q <= (div_q == div_top) ? '0 : div_q + DIV_W'(1);
  end

  always_comb begin
    if (clr)                 smp_en = 1'b0;
    else if (rate == RATE_CLK) smp_en = 1'b1;
    else                     smp_en = tick && (div_q == div_top);
  end
endmodule

// File: rtl/dgf_run_filter.sv
module dgf_run_filter
  import dgf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_en,
  input  logic             bypass,
  input  logic             smp,
  input  logic [RUN_W-1:0] run_len,
  output logic             level,
  output logic             rise,
  output logic             fall,
  output logic [RUN_W-1:0] run_cnt
);
  logic             last_q;
  logic             level_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] nxt_cnt;
  logic             same;
  logic             accept;
  logic             level_d;

  always_comb begin
    same = (run_q != '0) && (smp == last_q);
    if (!same)                nxt_cnt = RUN_W'(1);
    else if (run_q >= run_len) nxt_cnt = run_q;
    else                      nxt_cnt = run_q + RUN_W'(1);
    accept  = smp_en && (nxt_cnt >= run_len) && (smp != level_q);
    level_d = (bypass || accept) ? smp : level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (clr) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (smp_en && !bypass) begin
      run_q  <= nxt_cnt;
      last_q <= smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      rise    <= 1'b0;
      fall    <= 1'b0;
    end else begin
      level_q <= level_d;
      rise    <= level_d & ~level_q;
      fall    <= ~level_d & level_q;
    end
  end

  assign level   = level_q;
  assign run_cnt = run_q;
endmodule

// File: rtl/capin_deglitch.sv
module capin_deglitch
  import dgf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dts_tick,
  input  logic              raw_in,
  input  logic [CODE_W-1:0] flt_code,
  output logic              flt_level,
  output logic              rise_pulse,
  output logic              fall_pulse
);
  logic [CODE_W-1:0] code_q;
  logic              code_chg;
  logic              sync_lvl;
  logic              smp_en;
  logic              flt_bypass;
  logic [RUN_W-1:0]  run_len;
  logic [RUN_W-1:0]  run_cnt;
  flt_cfg_t          cfg;

  assign cfg        = decode_code(flt_code);
  assign flt_bypass = cfg.bypass;
  assign run_len    = cfg.run_len;
  assign code_chg   = (flt_code != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= flt_code;
  end

  dgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_lvl)
  );

  dgf_rate_gen #(.DIV_MAX(4)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (code_chg),
    .tick   (dts_tick),
    .rate   (cfg.rate),
    .smp_en (smp_en)
  );

  dgf_run_filter u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (code_chg),
    .smp_en  (smp_en),
    .bypass  (flt_bypass),
    .smp     (sync_lvl),
    .run_len (run_len),
    .level   (flt_level),
    .rise    (rise_pulse),
    .fall    (fall_pulse),
    .run_cnt (run_cnt)
  );
endmodule

// File: rtl/capin_deglitch_chk.sv
module capin_deglitch_chk
  import dgf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flt_level,
  input logic             rise_pulse,
  input logic             fall_pulse,
  input logic             smp_en,
  input logic             code_chg,
  input logic             byp,
  input logic [RUN_W-1:0] run_cnt,
  input logic [RUN_W-1:0] run_len
);
  // R8: edge pulses never coincide
  a_r8_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pulse && fall_pulse));

  // R8: rising pulse present exactly when the level has just risen
  a_r8_rise_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_level) |-> rise_pulse);
  a_r8_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> $rose(flt_level));

  // R8: falling pulse present exactly when the level has just fallen
  a_r8_fall_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_level) |-> fall_pulse);

  // R7: a code change empties the run count on the next edge
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(code_chg) |-> (run_cnt == '0));

  // R9: run count bounded by the run length under a stable filtering code
  a_r9_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_chg && !byp) |-> (run_cnt <= run_len));

  // R5: in filtering mode the level moves only on a sample edge
  a_r5_move_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ((flt_level != $past(flt_level)) && !$past(byp)) |-> $past(smp_en));
endmodule

bind capin_deglitch capin_deglitch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flt_level  (flt_level),
  .rise_pulse (rise_pulse),
  .fall_pulse (fall_pulse),
  .smp_en     (smp_en),
  .code_chg   (code_chg),
  .byp        (flt_bypass),
  .run_cnt    (run_cnt),
  .run_len    (run_len)
);

// File: tb/sim_capin_deglitch.sv
module sim_capin_deglitch;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dts_tick = 1'b0;
  logic       raw_in = 1'b0;
  logic [3:0] flt_code = 4'd0;
  logic       flt_level, rise_pulse, fall_pulse;

  int nvec = 0;
  int nbad = 0;
  int off = 0;
  int tick_p = 1;
  bit done = 0;

  capin_deglitch u0 (
    .clk(clk), .rst_n(rst_n), .dts_tick(dts_tick), .raw_in(raw_in),
    .flt_code(flt_code), .flt_level(flt_level),
    .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: set the tick for the coming edge, wait past it
  task automatic step();
    dts_tick = (((off + 1) % tick_p) == 0);
    @(posedge clk);
    off++;
    #1;
  endtask

  function automatic int run_len_of(input int c);
    case (c)
      1: return 2;  2: return 4;  3: return 8;
      4: return 6;  5: return 8;  6: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int div_of(input int c);
    if (c == 4 || c == 5) return 2;
    if (c == 6) return 4;
    return 1;
  endfunction

  // Settle output at lvl_old with the filter bypassed, then apply code c
  task automatic prepare(input int c, input bit lvl_old, input int p);
    tick_p = p;
    flt_code = 4'd0;
    raw_in = lvl_old;
    repeat (6) step();
    flt_code = 4'(c);
    off = -1;
    step();
  endtask

  task automatic latency_case(input int c, input bit lvl, input int p, input int d);
    int n, n_exp, neff, len, first, chg;
    bit got;
    string req;
    prepare(c, !lvl, p);
    repeat (d) step();
    raw_in = lvl;
    n = 0;
    got = 0;
    while (n < 300 && !got) begin
      step();
      n++;
      if (flt_level == lvl) got = 1;
    end
    len = run_len_of(c);
    if (len == 0) begin
      n_exp = 3;
      req = "R2";
    end else begin
      neff = (div_of(c) == 1) ? 1 : div_of(c) * p;
      first = ((d + 3 + neff - 1) / neff) * neff;
      chg = first + (len - 1) * neff;
      n_exp = chg - d;
      req = (div_of(c) == 1) ? "R3" : "R4/R7";
    end
    check(got && n == n_exp, req, n, n_exp);
    check((lvl ? rise_pulse : fall_pulse) == 1'b1, "R8", 0, 1);
    step();
    check(rise_pulse == 1'b0 && fall_pulse == 1'b0, "R8", int'(rise_pulse | fall_pulse), 0);
  endtask

  // Hold the new level for w cycles at clock rate, then return
  task automatic width_case(input int c, input bit lvl, input int w);
    int len;
    bit seen;
    len = run_len_of(c);
    prepare(c, !lvl, 1);
    repeat (4) step();
    raw_in = lvl;
    repeat (w) step();
    raw_in = !lvl;
    seen = 0;
    repeat (2 * len + 8) begin
      step();
      if (lvl ? rise_pulse : fall_pulse) seen = 1;
    end
    check(seen == (w >= len), "R5", int'(seen), int'(w >= len));
    check(flt_level == !lvl, "R5", int'(flt_level), int'(!lvl));
  endtask

  task automatic glitch_case(input int c, input bit lvl, input int p);
    bit seen;
    prepare(c, !lvl, p);
    seen = 0;
    repeat (20) begin
      step();
      if (rise_pulse || fall_pulse) seen = 1;
    end
    check(!seen && flt_level == !lvl, "R6", int'(seen), 0);
    raw_in = lvl;
    step();
    raw_in = !lvl;
    repeat (60) begin
      step();
      if (rise_pulse || fall_pulse) seen = 1;
    end
    check(!seen, "R6", int'(seen), 0);
    check(flt_level == !lvl, "R6", int'(flt_level), int'(!lvl));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    raw_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(flt_level == 0 && rise_pulse == 0 && fall_pulse == 0, "R1",
          int'(flt_level), 0);
    rst_n = 1'b1;
    step();
    check(flt_level == 0 && rise_pulse == 0 && fall_pulse == 0, "R1",
          int'({flt_level, rise_pulse, fall_pulse}), 0);
    step();
    check(flt_level == 0, "R1", int'(flt_level), 0);

    for (int p = 1; p <= 3; p += 2)
      for (int c = 0; c < 16; c++)
        for (int l = 0; l < 2; l++)
          latency_case(c, l[0], p, 5 + (c % 4));

    for (int c = 1; c <= 3; c++)
      for (int l = 0; l < 2; l++) begin
        width_case(c, l[0], run_len_of(c) - 1);
        width_case(c, l[0], run_len_of(c));
      end

    for (int c = 1; c <= 6; c++)
      for (int l = 0; l < 2; l++)
        glitch_case(c, l[0], 1);

    finish_run();
  end
endmodule